// File: doc/BRIEF.md
# Flash Ready/Busy Status Pin Controller

This block drives the open-drain status pin of a flash device. It watches the activity of the device's internal program/erase state machine and shows it to the host in one of two ways. In level mode the pin reads as a busy line. In the pulse modes it produces a fixed-width low pulse each time a selected kind of operation completes. The block never drives the pin high. Its only output is an enable that pulls the pin low, and an external resistor supplies the high level.

The host picks the mode over the command bus with a two-write sequence. First it writes the configuration opcode (B8h), and the next write carries the mode code. While an operation is suspended, or while reset is held, the level-mode pin reads as ready. This lets the host read from other blocks without seeing a false busy.

Top module: `sts_ready_pin`

## Requirements
- R1: In level mode (code 00h), when the state machine busy input is high and neither suspend input is high at a clock edge, the pull-low output is 1 from that edge on. This is one clock, well inside the 500 ns limit after a write strobe.
- R2: In level mode, when the busy input is low at a clock edge, the pull-low output is 0 (pin released) from that edge on.
- R3: In level mode, when the erase-suspend or program-suspend input is high at an edge, the pull-low output is 0 from that edge on, whatever the busy input is.
- R4: While the synchronous reset is high, the pull-low output is 0. Reset returns the mode to level mode and drops any half-entered configuration sequence.
- R5: A command write of B8h followed by a second command write with value 00h, 01h, 02h or 03h selects the mode. 00h is level mode, 01h pulses on erase completion, 02h pulses on program completion, and 03h pulses on either. The write after B8h is always taken as the code, even when it equals B8h.
- R6: A code write above 03h leaves the mode unchanged and ends the sequence.
- R7: Command writes not preceded by B8h do not change the mode.
- R8: In a pulse mode, a selected completion event seen at an edge makes the pull-low output 1 for exactly PULSE_CYC clocks starting at that edge. The default is 25 clocks, which is 500 ns at 50 MHz.
- R9: In a pulse mode, the busy and suspend inputs and completion events that were not selected have no effect on the pin. In level mode, completion events have no effect.
- R10: A selected completion event that arrives while a pulse is active restarts the pulse, so that PULSE_CYC clocks remain.
- R11: An accepted code write ends any pulse in progress at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also models the device reset being held |
| sm_busy_i | input | 1 | State machine is running an erase, program or lock-bit operation |
| erase_done_i | input | 1 | One-clock strobe: an erase has finished |
| prog_done_i | input | 1 | One-clock strobe: a program has finished |
| erase_susp_i | input | 1 | Erase is suspended |
| prog_susp_i | input | 1 | Program is suspended |
| cmd_wr_i | input | 1 | Command bus write strobe (one clock per write) |
| cmd_data_i | input | DATA_W | Command bus write data |
| sts_pull_low_o | output | 1 | 1 pulls the status pin low; 0 leaves it high-Z |

## Verification
The bench targets the handover points where a design is easy to get wrong. A suspend arriving while busy must release the pin, or the host would see a stuck busy. A second completion in mid-pulse must restart the count; a design that ignores it would end the pulse early. A mode change in mid-pulse must cut the pulse off, or a stale low would leak into level mode. The bench also sends out-of-range codes, a repeated B8h, and stray codes with no opcode. A decoder that accepts any of these would switch modes, and that shows up at once as a wrong pin level when busy or completion events follow.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    STS_LEVEL     = 2'd0,
    STS_PULSE_ERS = 2'd1,
    STS_PULSE_PRG = 2'd2,
    STS_PULSE_ANY = 2'd3
  } sts_mode_e;

  localparam int unsigned STS_CODE_MAX = 3;
endpackage

// File: rtl/sts_cfg_decode.sv
module sts_cfg_decode
  import sts_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] CFG_OPCODE = DATA_W'(8'hB8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output sts_mode_e         mode_o,
  output logic              mode_load_o
);
  localparam logic [DATA_W-1:0] CODE_MAX = DATA_W'(STS_CODE_MAX);

  logic      armed_q;
  sts_mode_e mode_q;
  logic      code_ok;

  // The write after the opcode is the code, whatever its value.
  assign code_ok     = (wr_data_i <= CODE_MAX);
  assign mode_load_o = armed_q && wr_valid_i && code_ok;
  assign mode_o      = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      mode_q  <= STS_LEVEL;
    end else if (wr_valid_i) begin
      if (armed_q) begin
        armed_q <= 1'b0;
        if (code_ok) mode_q <= sts_mode_e'(wr_data_i[1:0]);
      end else if (wr_data_i == CFG_OPCODE) begin
        armed_q <= 1'b1;
      end
    end
  end

  // R5
  code_take_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && wr_valid_i && code_ok) |=> (mode_q == sts_mode_e'($past(wr_data_i[1:0])) && !armed_q));

  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && wr_valid_i && !code_ok) |=> ($stable(mode_q) && !armed_q));

  // R7
  stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_q) |=> $stable(mode_q));
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int unsigned PULSE_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic fire_i,
  output logic active_next_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)             cnt_d = '0;
    else if (fire_i)       cnt_d = FULL;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  assign active_next_o = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_i && !clr_i) |=> (cnt_q == FULL));

  // R8
  min_width_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > 1 && !clr_i) |=> (cnt_q != '0));

  // R11
  cancel_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/sts_ready_pin.sv
module sts_ready_pin
  import sts_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PULSE_CYC = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sm_busy_i,
  input  logic              erase_done_i,
  input  logic              prog_done_i,
  input  logic              erase_susp_i,
  input  logic              prog_susp_i,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              sts_pull_low_o
);
  sts_mode_e mode_w;
  logic      mode_load_w;
  logic      fire_w;
  logic      pulse_next_w;
  logic      level_busy_w;
  logic      pull_q;

  sts_cfg_decode #(
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .wr_valid_i  (cmd_wr_i),
    .wr_data_i   (cmd_data_i),
    .mode_o      (mode_w),
    .mode_load_o (mode_load_w)
  );

  always_comb begin
    unique case (mode_w)
      STS_PULSE_ERS: fire_w = erase_done_i;
      STS_PULSE_PRG: fire_w = prog_done_i;
      STS_PULSE_ANY: fire_w = erase_done_i | prog_done_i;
      default:       fire_w = 1'b0;
    endcase
  end

  sts_pulse_timer #(
    .PULSE_CYC (PULSE_CYC)
  ) u_tmr (
    .clk           (clk),
    .rst           (rst),
    .clr_i         (mode_load_w),
    .fire_i        (fire_w),
    .active_next_o (pulse_next_w)
  );

  assign level_busy_w = sm_busy_i & ~erase_susp_i & ~prog_susp_i;

  always_ff @(posedge clk) begin
    if (rst)                      pull_q <= 1'b0;
    else if (mode_w == STS_LEVEL) pull_q <= level_busy_w;
    else                          pull_q <= pulse_next_w;
  end

  assign sts_pull_low_o = pull_q;

  // R1
  level_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_w == STS_LEVEL && sm_busy_i && !erase_susp_i && !prog_susp_i) |=> sts_pull_low_o);

  // R2
  level_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_w == STS_LEVEL && !sm_busy_i) |=> !sts_pull_low_o);

  // R3
  susp_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_w == STS_LEVEL && (erase_susp_i || prog_susp_i)) |=> !sts_pull_low_o);

  // R4
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (!sts_pull_low_o && mode_w == STS_LEVEL));

  // R9
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_w != STS_LEVEL && !fire_w && !sts_pull_low_o) |=> !sts_pull_low_o);
endmodule

// File: tb/sim_sts_ready_pin.sv
module sim_sts_ready_pin;
  localparam int PW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busy = 1'b0, ed = 1'b0, pd = 1'b0, es = 1'b0, ps = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       pin;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string tag     = "R4";

  // behavioural reference state
  int m_mode = 0, m_armed = 0, m_cnt = 0;
  bit m_out = 1'b0;

  always #10 clk = ~clk;

  sts_ready_pin #(.DATA_W(8), .PULSE_CYC(PW)) u0 (
    .clk(clk), .rst(rst), .sm_busy_i(busy), .erase_done_i(ed), .prog_done_i(pd),
    .erase_susp_i(es), .prog_susp_i(ps), .cmd_wr_i(wr), .cmd_data_i(wd),
    .sts_pull_low_o(pin)
  );

  always @(posedge clk) begin
    int  old_mode;
    bit  clr, ev;
    if (rst) begin
      m_mode = 0; m_armed = 0; m_cnt = 0; m_out = 1'b0;
    end else begin
      old_mode = m_mode;
      clr = 1'b0;
      if (wr) begin
        if (m_armed != 0) begin
          m_armed = 0;
          if (wd <= 8'h03) begin m_mode = int'(wd); clr = 1'b1; end
        end else if (wd == 8'hB8) m_armed = 1;
      end
      ev = (old_mode == 1 && ed) || (old_mode == 2 && pd) || (old_mode == 3 && (ed || pd));
      if (clr)           m_cnt = 0;
      else if (ev)       m_cnt = PW;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (old_mode == 0) m_out = busy && !es && !ps;
      else               m_out = (m_cnt != 0);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (pin !== m_out) begin
        n_fail++;
        $display("FAIL %s: pin actual=%b expected=%b at %0t", tag, pin, m_out, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] v);
    @(negedge clk); wr = 1'b1; wd = v;
    @(negedge clk); wr = 1'b0; wd = 8'h00;
  endtask

  task automatic cfg(input logic [7:0] code);
    cmd(8'hB8);
    cmd(code);
  endtask

  task automatic strobe_ed();
    @(negedge clk); ed = 1'b1;
    @(negedge clk); ed = 1'b0;
  endtask

  task automatic strobe_pd();
    @(negedge clk); pd = 1'b1;
    @(negedge clk); pd = 1'b0;
  endtask

  task automatic expect_pin(input bit v, input string t);
    n_tests++;
    if (pin !== v) begin
      n_fail++;
      $display("FAIL %s: pin actual=%b expected=%b at %0t", t, pin, v, $time);
    end
  endtask

  initial begin
    tag = "R4"; cyc(3); expect_pin(1'b0, "R4");
    @(negedge clk); rst = 1'b0;

    tag = "R1"; @(negedge clk); busy = 1'b1; cyc(1); expect_pin(1'b1, "R1");
    tag = "R3"; es = 1'b1; cyc(1); expect_pin(1'b0, "R3"); es = 1'b0; cyc(2);
    ps = 1'b1; cyc(1); expect_pin(1'b0, "R3"); ps = 1'b0; cyc(2);
    tag = "R2"; busy = 1'b0; cyc(1); expect_pin(1'b0, "R2");
    tag = "R9"; strobe_ed(); strobe_pd(); cyc(1); expect_pin(1'b0, "R9");

    tag = "R7"; cmd(8'h01); cmd(8'h02); @(negedge clk); busy = 1'b1; cyc(1);
    expect_pin(1'b1, "R7"); busy = 1'b0; cyc(2);

    tag = "R5"; cfg(8'h01); cyc(1);
    tag = "R8"; strobe_ed(); expect_pin(1'b1, "R8"); cyc(PW + 2); expect_pin(1'b0, "R8");
    tag = "R9"; strobe_pd(); busy = 1'b1; cyc(3); expect_pin(1'b0, "R9"); busy = 1'b0;

    tag = "R6"; cfg(8'h05); strobe_ed(); expect_pin(1'b1, "R6"); cyc(PW + 1);
    tag = "R6"; cmd(8'hB8); cmd(8'hB8); cmd(8'h00); strobe_ed(); expect_pin(1'b1, "R6"); cyc(PW + 1);

    tag = "R5"; cfg(8'h02); strobe_ed(); cyc(1); expect_pin(1'b0, "R5");
    tag = "R8"; strobe_pd(); expect_pin(1'b1, "R8"); cyc(PW + 1);
    tag = "R5"; cfg(8'h03); strobe_ed(); cyc(PW + 1); strobe_pd(); cyc(PW + 1);

    tag = "R10"; strobe_ed(); cyc(3); strobe_pd(); cyc(PW - 2); expect_pin(1'b1, "R10"); cyc(4);

    tag = "R11"; strobe_ed(); cyc(2); cfg(8'h00); cyc(1); expect_pin(1'b0, "R11");
    busy = 1'b1; cyc(1); expect_pin(1'b1, "R11"); busy = 1'b0; cyc(2);

    tag = "R4"; cfg(8'h01); cmd(8'hB8); strobe_ed(); @(negedge clk); rst = 1'b1; cyc(2);
    expect_pin(1'b0, "R4"); @(negedge clk); rst = 1'b0;
    cmd(8'h02); busy = 1'b1; cyc(1); expect_pin(1'b1, "R4"); busy = 1'b0; cyc(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule